// File: doc/BRIEF.md
# Status Register Write-Protect Gate

This block keeps the protection fields of a serial flash status register and decides, for each write-status request, whether the new value may be stored. A lock-down bit can freeze the register, but only while the active-low hardware write-protect pin is held low. With the pin high, software can always rewrite the protection fields, including clearing the lock-down bit itself.

The command decoder raises a one-cycle request with a data byte. One clock later the block answers with exactly one pulse: either accepted or rejected. An accepted write takes effect at that same edge. The assembled status byte carries the protection fields next to two flags that are owned elsewhere and passed straight through: a busy flag and a write-enable flag. The block-protect level is also exported on its own for the array write path, which maps it to address ranges.

Top module: `sr_protect_gate`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the lock-down bit (status bit 7), loads the block-protect level with parameter BP_RESET (default 2'b11), and clears both response pulses.
- R2: With wp_n high when a request is sampled, the write is accepted whatever the lock-down bit holds, including a write that clears it.
- R3: With wp_n low and lock-down bit 0 when a request is sampled, the write is accepted.
- R4: With wp_n low and lock-down bit 1 when a request is sampled, the write is rejected and status bits 7 and 3:2 are left unchanged.
- R5: An accepted write loads status bit 7 from wr_data bit 7 and the block-protect level (status bits 3:2, bit 3 the upper) from wr_data bits 3:2, visible from the edge that samples the request.
- R6: Status bit 0 always shows busy_in, bit 1 always shows wel_in, and bits 6:4 read 0; no write data changes them.
- R7: Each request produces exactly one one-cycle pulse on wr_ok or wr_rej in the cycle after it is sampled; with no request both stay low.
- R8: bp_level always equals status bits 3:2.
- R9: wp_n matters only in a cycle with a request; changing it with no request leaves the register unchanged.
- R10: Without an accepted request, status bits 7 and 3:2 hold their value, also across back-to-back rejected requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n | input | 1 | Hardware write-protect pin level, active low |
| wr_req | input | 1 | One-cycle write-status request strobe |
| wr_data | input | 8 | Proposed status byte |
| busy_in | input | 1 | Busy flag from the program/erase engine |
| wel_in | input | 1 | Write-enable flag from the command decoder |
| status | output | 8 | Assembled status byte |
| wr_ok | output | 1 | Pulse: request accepted |
| wr_rej | output | 1 | Pulse: request rejected |
| bp_level | output | 2 | Block-protect level for the array write path |

## Verification
The hardest case to reach is a rejected write. The register must first be locked, which takes an accepted write with bit 7 set. Then the pin must be pulled low, and only then does a request carrying different data arrive. The stimulus builds this chain on purpose. It then repeats the request back to back and toggles the pin between requests with no strobe. Finally it raises the pin to show that the same lock-down bit no longer blocks a write, and that such a write may clear the lock.

// File: rtl/sr_gate_pkg.sv
// Shared constants and types for the status register write-protect gate.
// Assumes an 8-bit status byte with the lock-down bit at the top.
package sr_gate_pkg;
    localparam int SR_W     = 8;
    localparam int LOCK_POS = 7;
    localparam int BUSY_POS = 0;
    localparam int WEL_POS  = 1;
    localparam int BP_LSB   = 2;

    typedef enum logic [1:0] {
        RESP_NONE = 2'b00,
        RESP_OK   = 2'b01,
        RESP_REJ  = 2'b10
    } resp_e;
endpackage

// File: rtl/sr_lock_decide.sv
// Lock-down decision: a write is allowed unless the pin is low and the lock bit is set.
// Assumes wp_n is already synchronous to clk.
module sr_lock_decide (
    input  logic wp_n,
    input  logic lock_q,
    output logic allow
);
    // Combine the hardware pin with the stored software lock
    always_comb begin
        allow = wp_n || !lock_q;
    end
endmodule

// File: rtl/sr_prot_regs.sv
// Storage for the lock-down bit and the block-protect level.
// Assumes wr_en is a single-cycle qualified write from the decision logic.
module sr_prot_regs #(
    parameter int              NUM_BP   = 2,
    parameter logic [NUM_BP-1:0] BP_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              lock_d,
    input  logic [NUM_BP-1:0] bp_d,
    output logic              lock_q,
    output logic [NUM_BP-1:0] bp_q
);
    // Lock-down bit: cleared on reset, loaded on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)     lock_q <= 1'b0;
        else if (wr_en) lock_q <= lock_d;
    end

    // One flop per block-protect bit, each with its own reset value
    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        always_ff @(posedge clk) begin
            if (!rst_n)     bp_q[g] <= BP_RESET[g];
            else if (wr_en) bp_q[g] <= bp_d[g];
        end
    end
endmodule

// File: rtl/sr_resp_pulse.sv
// Registered one-cycle accepted/rejected response for every request.
// Assumes req is never held for more than one cycle per command.
module sr_resp_pulse
    import sr_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic allow,
    output logic ok,
    output logic rej
);
    resp_e resp_q;

    // Record the outcome of the request sampled at this edge
    always_ff @(posedge clk) begin
        if (!rst_n)   resp_q <= RESP_NONE;
        else if (req) resp_q <= allow ? RESP_OK : RESP_REJ;
        else          resp_q <= RESP_NONE;
    end

    // Decode the stored outcome onto the two pulse outputs
    always_comb begin
        ok  = (resp_q == RESP_OK);
        rej = (resp_q == RESP_REJ);
    end
endmodule

// File: rtl/sr_protect_gate.sv
// Top of the status register write-protect gate: decides each write-status request,
// stores the protection fields and assembles the status byte.
// Assumes all inputs are synchronous to clk and wr_req is a one-cycle strobe.
module sr_protect_gate
    import sr_gate_pkg::*;
#(
    parameter int                NUM_BP   = 2,
    parameter logic [NUM_BP-1:0] BP_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              wr_req,
    input  logic [SR_W-1:0]   wr_data,
    input  logic              busy_in,
    input  logic              wel_in,
    output logic [SR_W-1:0]   status,
    output logic              wr_ok,
    output logic              wr_rej,
    output logic [NUM_BP-1:0] bp_level
);
    localparam logic [SR_W-1:0] WR_MASK =
        (SR_W'(1) << LOCK_POS) | (SR_W'((1 << NUM_BP) - 1) << BP_LSB);

    logic              allow;
    logic              lock_q;
    logic [NUM_BP-1:0] bp_q;
    logic [SR_W-1:0]   ignored_unused;

    assign ignored_unused = wr_data & ~WR_MASK;

    sr_lock_decide u_decide (
        .wp_n   (wp_n),
        .lock_q (lock_q),
        .allow  (allow)
    );

    sr_prot_regs #(.NUM_BP(NUM_BP), .BP_RESET(BP_RESET)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_req && allow),
        .lock_d (wr_data[LOCK_POS]),
        .bp_d   (wr_data[BP_LSB +: NUM_BP]),
        .lock_q (lock_q),
        .bp_q   (bp_q)
    );

    sr_resp_pulse u_resp (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (wr_req),
        .allow (allow),
        .ok    (wr_ok),
        .rej   (wr_rej)
    );

    // Assemble the status byte from stored fields and pass-through flags
    always_comb begin
        status                     = '0;
        status[BUSY_POS]           = busy_in;
        status[WEL_POS]            = wel_in;
        status[BP_LSB +: NUM_BP]   = bp_q;
        status[LOCK_POS]           = lock_q;
    end

    // Export the protect level for the array write path
    always_comb begin
        bp_level = bp_q;
    end
endmodule

// File: rtl/sr_gate_chk.sv
// Temporal checks for sr_protect_gate, attached by bind.
module sr_gate_chk
    import sr_gate_pkg::*;
#(
    parameter int                NUM_BP   = 2,
    parameter logic [NUM_BP-1:0] BP_RESET = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic              wr_req,
    input logic [SR_W-1:0]   wr_data,
    input logic [SR_W-1:0]   status,
    input logic              wr_ok,
    input logic              wr_rej,
    input logic [NUM_BP-1:0] bp_level
);
    logic [SR_W-1:0] chk_unused;
    assign chk_unused = status;

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!status[LOCK_POS] && bp_level == BP_RESET && !wr_ok && !wr_rej));

    p_accept_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && (wp_n || !status[LOCK_POS])) |=>
        (wr_ok && !wr_rej && status[LOCK_POS] == $past(wr_data[LOCK_POS])
         && bp_level == $past(wr_data[BP_LSB +: NUM_BP])));

    p_reject_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wp_n && status[LOCK_POS]) |=>
        (wr_rej && !wr_ok && $stable(status[LOCK_POS]) && $stable(bp_level)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> (!wr_ok && !wr_rej && $stable(status[LOCK_POS]) && $stable(bp_level)));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ok, wr_rej}));
endmodule

bind sr_protect_gate sr_gate_chk #(.NUM_BP(NUM_BP), .BP_RESET(BP_RESET)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .wr_req   (wr_req),
    .wr_data  (wr_data),
    .status   (status),
    .wr_ok    (wr_ok),
    .wr_rej   (wr_rej),
    .bp_level (bp_level)
);

// File: tb/test_sr_protect_gate.sv
// Bench: behavioural model updated on each clock, compared at every falling edge.
module test_sr_protect_gate;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_n = 1'b1;
    logic       wr_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       busy_in = 1'b0;
    logic       wel_in = 1'b0;
    logic [7:0] status;
    logic       wr_ok, wr_rej;
    logic [1:0] bp_level;

    int checks = 0;
    int errors = 0;

    // Model state
    int m_lock = 0;
    int m_bp   = 3;
    int m_ok   = 0;
    int m_rej  = 0;

    sr_protect_gate i_sr_protect_gate (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wr_req(wr_req), .wr_data(wr_data),
        .busy_in(busy_in), .wel_in(wel_in), .status(status), .wr_ok(wr_ok),
        .wr_rej(wr_rej), .bp_level(bp_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, advance the model at the edge, compare after it
    task automatic step(input string tag, input bit rst, input bit wp, input bit req,
                        input logic [7:0] d, input bit busy, input bit wel);
        int exp_status;
        rst_n = rst; wp_n = wp; wr_req = req; wr_data = d; busy_in = busy; wel_in = wel;
        @(posedge clk);
        if (!rst) begin
            m_lock = 0; m_bp = 3; m_ok = 0; m_rej = 0;
        end else if (req) begin
            if (wp || m_lock == 0) begin
                m_lock = d[7]; m_bp = d[3:2]; m_ok = 1; m_rej = 0;
            end else begin
                m_ok = 0; m_rej = 1;
            end
        end else begin
            m_ok = 0; m_rej = 0;
        end
        @(negedge clk);
        exp_status = (m_lock << 7) | (m_bp << 2) | (int'(wel) << 1) | int'(busy);
        check(tag, "status", status, exp_status);
        check("R7", "wr_ok", wr_ok, m_ok);
        check("R7", "wr_rej", wr_rej, m_rej);
        check("R8", "bp_level", bp_level, m_bp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        step("R1", 0, 1, 0, 8'h00, 0, 0);
        step("R1", 0, 1, 1, 8'h80, 0, 0);   // request during reset is ignored
        step("R10", 1, 1, 0, 8'h00, 0, 0);
        // R2/R5: pin high, lock with level 2'b01
        step("R5", 1, 1, 1, 8'h84, 0, 0);
        step("R10", 1, 1, 0, 8'h00, 0, 0);
        // R4: pin low, locked: rejected, back to back
        step("R4", 1, 0, 1, 8'h08, 0, 0);
        step("R4", 1, 0, 1, 8'h00, 1, 1);
        step("R10", 1, 0, 0, 8'h00, 0, 0);
        // R9: pin toggles without request
        step("R9", 1, 1, 0, 8'h00, 0, 1);
        step("R9", 1, 0, 0, 8'h00, 1, 0);
        // R2: pin high overrides the lock and clears it
        step("R2", 1, 1, 1, 8'h08, 0, 0);
        // R3: pin low, unlocked: accepted
        step("R3", 1, 0, 1, 8'h0C, 0, 0);
        step("R3", 1, 0, 1, 8'h80, 0, 0);    // relock while pin low
        step("R4", 1, 0, 1, 8'h0C, 0, 0);
        // R6: read-only bits ignore write data, flags pass through
        step("R6", 1, 1, 1, 8'h73, 0, 0);
        step("R6", 1, 1, 0, 8'h00, 1, 1);
        step("R6", 1, 1, 1, 8'hFF, 1, 0);
        // R1: reset mid-operation
        step("R1", 0, 0, 0, 8'h00, 0, 0);
        step("R3", 1, 0, 1, 8'h00, 0, 0);
        step("R10", 1, 1, 0, 8'hFF, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule